// File: doc/BRIEF.md
# Stacking Bus Expansion Port Controller

This block connects one repeater to a shared stacking bus that an external arbiter controls. When the local repeater has receive activity, the block raises a request toward the arbiter. It places its 5-bit symbols on the bus only after the arbiter's active-low enable has been seen and filtered. While it drives, it sends a forwarded data clock that other stacked devices use to sample the symbols. It also acknowledges the grant, and it passes a synchronized indication to the repeater core when another device is carrying data on the bus.

On the jam side, the block merges each port's carrier-integrity jam request with internal collisions to form the outgoing jam line. An internal collision does not count while an incoming forced-jam request is in effect. The incoming forced-jam request is filtered the same way as the grant, and the result tells every local port to send jam. The bus pins are modelled as separate output, output-enable and input signals, so the bus stays an input unless the enable is high.

Top module: `exp_port_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0: bus_req_o, grant_ack_o, bus_oe_o, bus_data_o, bus_clk_o, jam_out_o, jam_all_o and bus_busy_o.
- R2: The grant input grant_ni is active low. A low pulse that is present at only one rising clock edge leaves grant_ack_o and bus_oe_o unchanged.
- R3: Let x[n] be ~grant_ni sampled at rising edge n. After edge n, grant_ack_o takes the value x[n-2] when x[n-2] equals x[n-3], and otherwise keeps its previous value. A grant held for two edges therefore shows up three edges after it is first sampled.
- R4: Release of the grant is filtered the same way as its assertion. bus_oe_o equals grant_ack_o in every cycle, so it falls in the same cycle the filtered grant deasserts.
- R5: bus_data_o equals the loc_data_i value sampled at the most recent edge while bus_oe_o is 1, and is 0 while bus_oe_o is 0.
- R6: bus_req_o equals loc_act_i sampled at the previous rising edge.
- R7: bus_clk_o is the inverted local clock while bus_oe_o is 1 and is held low otherwise. It therefore rises mid-cycle, half a period after bus_data_o changes.
- R8: jam_all_o follows jam_req_i (active high) through the same two-sample filter and the same timing as in R3.
- R9: After each edge, jam_out_o equals the OR of all port_jam_i bits, ORed with (int_col_i AND NOT jam_all_o), where all inputs are sampled at that edge and jam_all_o is the value from before the edge.
- R10: bus_busy_o equals bus_crs_i delayed by two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz local symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_act_i | input | 1 | Local ports have data to forward |
| loc_data_i | input | DW | Local 5-bit symbol |
| port_jam_i | input | NPORT | Per-port carrier-integrity jam requests |
| int_col_i | input | 1 | Internal collision flag |
| grant_ni | input | 1 | Arbiter bus enable, active low |
| jam_req_i | input | 1 | Incoming forced-jam request |
| bus_crs_i | input | 1 | Bus carrier sense from other devices |
| bus_req_o | output | 1 | Bus request toward the arbiter |
| grant_ack_o | output | 1 | Filtered grant acknowledge |
| bus_oe_o | output | 1 | Drive enable for the bus data pins |
| bus_data_o | output | DW | Symbol driven onto the bus |
| bus_clk_o | output | 1 | Forwarded data clock |
| jam_out_o | output | 1 | Merged jam output |
| jam_all_o | output | 1 | Filtered forced jam to all local ports |
| bus_busy_o | output | 1 | Synchronized bus activity to the repeater core |

## Verification
An internal collision can arrive in the same cycle that a filtered incoming jam is in effect. In that case the collision must be kept out of jam_out_o, while a port jam in the same cycle must still appear. The bench drives an internal collision both during and after a held jam request, and also drives random overlaps of collisions, jam pulses of one and two cycles, and port jams. The reference model checks jam_out_o against the jam_all_o value from before each edge.

// File: rtl/exp_port_pkg.sv
package exp_port_pkg;
  localparam int SYM_W_DEF  = 5;
  localparam int NPORT_DEF  = 8;
  localparam int SYNC_DEF   = 2;
endpackage

// File: rtl/exp_glitch_filter.sv
module exp_glitch_filter #(
  parameter int SYNC  = 2,
  parameter bit AGREE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LEN = AGREE ? SYNC + 1 : SYNC;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LEN-2:0], d_i};
  end

  generate
    if (AGREE) begin : g_agree
      logic f_q;
      // change state only when two consecutive synced samples agree
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           f_q <= 1'b0;
        else if (sh_q[SYNC-1] == sh_q[SYNC])   f_q <= sh_q[SYNC-1];
      end
      assign q_o = f_q;
    end else begin : g_plain
      assign q_o = sh_q[SYNC-1];
    end
  endgenerate
endmodule

// File: rtl/exp_jam_merge.sv
module exp_jam_merge #(
  parameter int NPORT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] port_jam_i,
  input  logic             int_col_i,
  input  logic             jam_in_f_i,
  output logic             jam_out_o
);
  logic jam_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jam_q <= 1'b0;
    else         jam_q <= (|port_jam_i) | (int_col_i & ~jam_in_f_i);
  end
  assign jam_out_o = jam_q;

  // R9: collisions during incoming jam are not reported
  p_col_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam_in_f_i && port_jam_i == '0) |=> !jam_out_o);
  p_port_jam_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_jam_i != '0) |=> jam_out_o);
endmodule

// File: rtl/exp_bus_drive.sv
module exp_bus_drive #(
  parameter int DW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_f_i,
  input  logic          act_i,
  input  logic [DW-1:0] data_i,
  output logic          req_o,
  output logic          oe_o,
  output logic [DW-1:0] data_o,
  output logic          clk_o
);
  logic          act_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      act_q  <= act_i;
      data_q <= data_i;
    end
  end

  assign req_o  = act_q;
  assign oe_o   = grant_f_i;
  assign data_o = oe_o ? data_q : '0;
  // inverted clock: enable changes only while this output is already low
  assign clk_o  = ~clk_i & oe_o;

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> data_o == '0);
  p_drive_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && oe_o) |-> data_o == $past(data_i));
  p_req_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> req_o == $past(act_i));
endmodule

// File: rtl/exp_port_ctrl.sv
module exp_port_ctrl
  import exp_port_pkg::*;
#(
  parameter int DW    = SYM_W_DEF,
  parameter int NPORT = NPORT_DEF,
  parameter int SYNC  = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loc_act_i,
  input  logic [DW-1:0]    loc_data_i,
  input  logic [NPORT-1:0] port_jam_i,
  input  logic             int_col_i,
  input  logic             grant_ni,
  input  logic             jam_req_i,
  input  logic             bus_crs_i,
  output logic             bus_req_o,
  output logic             grant_ack_o,
  output logic             bus_oe_o,
  output logic [DW-1:0]    bus_data_o,
  output logic             bus_clk_o,
  output logic             jam_out_o,
  output logic             jam_all_o,
  output logic             bus_busy_o
);
  logic grant_f, jam_f;

  exp_glitch_filter #(.SYNC(SYNC), .AGREE(1'b1)) u_grant_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(~grant_ni), .q_o(grant_f));

  exp_glitch_filter #(.SYNC(SYNC), .AGREE(1'b1)) u_jam_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(jam_req_i), .q_o(jam_f));

  exp_glitch_filter #(.SYNC(SYNC), .AGREE(1'b0)) u_crs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_crs_i), .q_o(bus_busy_o));

  exp_jam_merge #(.NPORT(NPORT)) u_jam (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_jam_i(port_jam_i),
    .int_col_i(int_col_i), .jam_in_f_i(jam_f), .jam_out_o(jam_out_o));

  exp_bus_drive #(.DW(DW)) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .grant_f_i(grant_f),
    .act_i(loc_act_i), .data_i(loc_data_i), .req_o(bus_req_o),
    .oe_o(bus_oe_o), .data_o(bus_data_o), .clk_o(bus_clk_o));

  assign grant_ack_o = grant_f;
  assign jam_all_o   = jam_f;

  // R3/R2: a rise needs two consecutive low samples of the enable
  p_grant_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_ack_o) |-> (!$past(grant_ni, 3) && !$past(grant_ni, 4)));
  // R4: release needs two consecutive high samples
  p_grant_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_ack_o) |-> ($past(grant_ni, 3) && $past(grant_ni, 4)));
  p_oe_granted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> grant_ack_o);
  p_jam_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_all_o) |-> ($past(jam_req_i, 3) && $past(jam_req_i, 4)));
endmodule

// File: tb/exp_port_ctrl_tb.sv
module exp_port_ctrl_tb;
  localparam int PERIOD = 40;
  localparam int DW = 5;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic loc_act = 1'b0;
  logic [DW-1:0] loc_data = '0;
  logic [NP-1:0] port_jam = '0;
  logic int_col = 1'b0, grant_n = 1'b1, jam_req = 1'b0, crs = 1'b0;
  logic bus_req, grant_ack, bus_oe, bus_clk, jam_out, jam_all, bus_busy;
  logic [DW-1:0] bus_data;

  always #(PERIOD/2) clk = ~clk;

  exp_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .loc_act_i(loc_act), .loc_data_i(loc_data),
    .port_jam_i(port_jam), .int_col_i(int_col), .grant_ni(grant_n),
    .jam_req_i(jam_req), .bus_crs_i(crs), .bus_req_o(bus_req),
    .grant_ack_o(grant_ack), .bus_oe_o(bus_oe), .bus_data_o(bus_data),
    .bus_clk_o(bus_clk), .jam_out_o(jam_out), .jam_all_o(jam_all),
    .bus_busy_o(bus_busy));

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic g1, g2, g3, gf, j1, j2, j3, jf, c1, c2, act_e, jamo_e;
  logic [DW-1:0] dq_e;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic filt_next(input logic cur, input logic a2, input logic a3);
    return (a2 == a3) ? a2 : cur;
  endfunction

  task automatic model_reset();
    {g1, g2, g3, gf, j1, j2, j3, jf, c1, c2, act_e, jamo_e} = '0;
    dq_e = '0;
  endtask

  task automatic cycle();
    @(posedge clk);
    jamo_e = (|port_jam) | (int_col & ~jf);
    gf = filt_next(gf, g2, g3);
    g3 = g2; g2 = g1; g1 = ~grant_n;
    jf = filt_next(jf, j2, j3);
    j3 = j2; j2 = j1; j1 = jam_req;
    c2 = c1; c1 = crs;
    act_e = loc_act; dq_e = loc_data;
    #2;
    chk("R3 grant_ack", grant_ack, gf);
    chk("R4 bus_oe", bus_oe, gf);
    chk("R5 bus_data", bus_data, gf ? dq_e : '0);
    chk("R6 bus_req", bus_req, act_e);
    chk("R8 jam_all", jam_all, jf);
    chk("R9 jam_out", jam_out, jamo_e);
    chk("R10 bus_busy", bus_busy, c2);
    chk("R7 bus_clk high phase", bus_clk, 1'b0);
    @(negedge clk);
    #1;
    chk("R7 bus_clk low phase", bus_clk, gf);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    grant_n = 1'b0; jam_req = 1'b1; crs = 1'b1; loc_act = 1'b1; int_col = 1'b1;
    #1;
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset grant_ack", grant_ack, 0);
    chk("R1 reset bus_oe", bus_oe, 0);
    chk("R1 reset bus_data", bus_data, 0);
    chk("R1 reset bus_clk", bus_clk, 0);
    chk("R1 reset jam_out", jam_out, 0);
    chk("R1 reset jam_all", jam_all, 0);
    chk("R1 reset bus_busy", bus_busy, 0);
    @(negedge clk);
    grant_n = 1'b1; jam_req = 1'b0; crs = 1'b0; loc_act = 1'b0; int_col = 1'b0;
    rst_ni = 1'b1;
    idle_n(4);

    // R2: single-edge grant pulse must be ignored
    grant_n = 1'b0; loc_data = 5'h15; loc_act = 1'b1; cycle();
    grant_n = 1'b1; idle_n(5);
    chk("R2 short grant ignored", grant_ack, 1'b0);
    // R3: held grant
    grant_n = 1'b0; loc_data = 5'h0a; idle_n(6);
    chk("R3 held grant seen", grant_ack, 1'b1);
    // R4: single-edge release glitch ignored, then real release
    grant_n = 1'b1; cycle(); grant_n = 1'b0; idle_n(5);
    chk("R4 release glitch ignored", bus_oe, 1'b1);
    grant_n = 1'b1; loc_act = 1'b0; idle_n(5);
    chk("R4 released", bus_oe, 1'b0);
    // R8/R9: collision while jam is filtered in, plus port jam overlap
    jam_req = 1'b1; int_col = 1'b1; idle_n(6);
    chk("R9 collision masked under jam", jam_out, 1'b0);
    port_jam = 8'h40; cycle();
    chk("R9 port jam passes under jam", jam_out, 1'b1);
    port_jam = '0; jam_req = 1'b0; idle_n(6);
    chk("R9 collision after jam", jam_out, 1'b1);
    int_col = 1'b0; crs = 1'b1; idle_n(3);
    chk("R10 busy", bus_busy, 1'b1);
    crs = 1'b0; idle_n(3);

    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 2) == 0) grant_n = ~grant_n;
      if ($urandom_range(0, 3) == 0) jam_req = ~jam_req;
      crs      = $urandom_range(0, 1) == 1;
      loc_act  = $urandom_range(0, 1) == 1;
      loc_data = DW'($urandom);
      int_col  = $urandom_range(0, 3) == 0;
      port_jam = ($urandom_range(0, 7) == 0) ? NP'(1 << $urandom_range(0, NP-1)) : '0;
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule